// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous requester and a 128K x 8 asynchronous static RAM. The requester presents a read or write with a 17-bit address and, for writes, an 8-bit data byte, and holds the request until the block acknowledges it. The block then produces the memory's control pins: an active-low select, an active-high select, an active-low write strobe and an active-low output enable. It also owns the data lines toward the memory, as an output value with a drive enable and a separate input, and it returns the byte it read.

Every memory timing limit is given in nanoseconds as a parameter. The block converts each limit to a whole number of clocks, rounding up, with a clock-period parameter. Reads hold the device selected with output enable low until the longest access limit has elapsed. The read byte is sampled on the closing edge of that window. The bus is then released for the output-disable time before the cycle is acknowledged. Writes select the device and drop the write strobe in the same clock, so the device never turns on its own outputs. Output enable stays high throughout. The write ends by releasing strobe and selects on one edge, with address and data held one clock longer.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During reset and whenever no cycle is in progress, the memory is deselected (active-low select 1, active-high select 0), write strobe and output enable are 1, the data drive enable is 0 and the acknowledge is 0.
- R2: The two select pins always agree: the active-low select is 0 exactly when the active-high select is 1.
- R3: A read holds the memory selected, write strobe 1 and output enable 0 for RD = ceil(max(read cycle, address access, enable access) / clock period) clocks, starting the clock after the request is taken; 18 clocks with default parameters.
- R4: Read data is the memory input sampled at the clock edge that closes the read window, and it is presented on the read-data port, unchanged, from then until the next read completes.
- R5: After the read window the memory is deselected with output enable 1 and the drive enable 0 for OD = ceil(output-disable time / clock period) clocks (7 by default), followed by the acknowledge clock.
- R6: A write holds the memory selected, write strobe 0, output enable 1 and the drive enable 1 for WP = ceil(max(write cycle, pulse width, select setup, address setup, data setup) / clock period) clocks (18 by default), starting the clock after the request is taken.
- R7: The drive enable is 1 only while output enable is 1. The address and the write data on the bus equal the values captured when the request was taken, for every clock of the cycle.
- R8: A write ends with write strobe and both selects released on the same edge, then one hold clock (ceil of the data-hold time, minimum 1) with the drive enable still 1 and the memory deselected, then the acknowledge clock.
- R9: The acknowledge is 1 for exactly one clock per cycle. A request is taken only when the block is idle and the acknowledge is 0. Request inputs that change while a cycle is in progress have no effect on that cycle.
- R10: Each converted count is the nanosecond limit divided by the clock period and rounded up, with a minimum of one clock. The lengths of the read window and the write pulse follow that rule exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request address |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| mem_addr | output | 17 | Memory address pins |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data arriving from the memory |

## Verification
The hardest case to reach from the ports is a read sampled one clock too early. A memory model that always returns correct data would hide it, so the bench's memory returns a poison byte until the selected-and-enabled time reaches the access limit. A shortened read window then returns the wrong byte. Request inputs that change in the middle of a cycle are the second hard case. The bench alters the address and data several clocks after a write is taken. It then reads back both addresses to show that only the captured pair reached the memory. Back-to-back requests with the valid held high check that nothing is taken during the acknowledge clock.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_HIZ   = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_WR_HOLD  = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic sel;
    logic we_n;
    logic oe_n;
    logic drive;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

  // Nanoseconds to clocks, rounded up, never below one clock.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels belonging to each sequencer state.
  function automatic strobe_t strobes_for(input seq_state_t s);
    strobe_t v;
    v = STROBE_IDLE;
    case (s)
      ST_RD_ACC: begin
        v.sel  = 1'b1;
        v.oe_n = 1'b0;
      end
      ST_WR_PULSE: begin
        v.sel   = 1'b1;
        v.we_n  = 1'b0;
        v.drive = 1'b1;
      end
      ST_WR_HOLD: v.drive = 1'b1;
      default: ;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= load_val;
    else if (!expired) cnt_q <= cnt_q - 1'b1;
  end

  // R10: a freshly loaded count runs down one step per clock
  a_r10_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CW       = 5,
  parameter int unsigned RD_CYC   = 18,
  parameter int unsigned OD_CYC   = 7,
  parameter int unsigned WP_CYC   = 18,
  parameter int unsigned HOLD_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          expired,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          accept,
  output logic          rd_sample,
  output strobe_t       strobe,
  output logic          ack
);

  seq_state_t state_q, state_d;
  strobe_t    strobe_q;
  logic       ack_q, ack_d;

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    load_val  = '0;
    ack_d     = 1'b0;
    accept    = 1'b0;
    rd_sample = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid && !ack_q) begin
          accept  = 1'b1;
          load    = 1'b1;
          state_d = req_write ? ST_WR_PULSE : ST_RD_ACC;
          load_val = req_write ? CW'(WP_CYC - 1) : CW'(RD_CYC - 1);
        end
      end
      ST_RD_ACC: begin
        if (expired) begin
          rd_sample = 1'b1;
          load      = 1'b1;
          load_val  = CW'(OD_CYC - 1);
          state_d   = ST_RD_HIZ;
        end
      end
      ST_RD_HIZ: begin
        if (expired) begin
          ack_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WR_PULSE: begin
        if (expired) begin
          load     = 1'b1;
          load_val = CW'(HOLD_CYC - 1);
          state_d  = ST_WR_HOLD;
        end
      end
      ST_WR_HOLD: begin
        if (expired) begin
          ack_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      strobe_q <= STROBE_IDLE;
      ack_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobes_for(state_d);
      ack_q    <= ack_d;
    end
  end

  assign strobe = strobe_q;
  assign ack    = ack_q;

  // R9: completion pulse lasts one clock
  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  // R1: idle state leaves pins quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (strobe_q == STROBE_IDLE));

  // R3: read window is not left before the timer runs out
  a_r3_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACC && !expired) |=> (state_q == ST_RD_ACC));

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          rd_sample,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      wdata    <= '0;
      rd_data  <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        wdata    <= req_wdata;
      end
      if (rd_sample) rd_data <= mem_dq_in;
    end
  end

  // R4: returned byte only moves on a sampling edge
  a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sample |=> $stable(rd_data));

  // R9: captured request only moves when a request is taken
  a_r9_capture_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(mem_addr) && $stable(wdata)));

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 17,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned T_RC_NS      = 70,
  parameter int unsigned T_AA_NS      = 70,
  parameter int unsigned T_OE_NS      = 35,
  parameter int unsigned T_OD_NS      = 25,
  parameter int unsigned T_WC_NS      = 70,
  parameter int unsigned T_WP_NS      = 55,
  parameter int unsigned T_CW_NS      = 65,
  parameter int unsigned T_AW_NS      = 65,
  parameter int unsigned T_DS_NS      = 30,
  parameter int unsigned T_DH_NS      = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned RD_CYC = ns_to_cycles(
    max_of(max_of(T_RC_NS, T_AA_NS), T_OE_NS), CLK_PERIOD_NS);
  localparam int unsigned OD_CYC = ns_to_cycles(T_OD_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_CYC = ns_to_cycles(
    max_of(max_of(max_of(T_WC_NS, T_WP_NS), max_of(T_CW_NS, T_AW_NS)), T_DS_NS),
    CLK_PERIOD_NS);
  localparam int unsigned HOLD_CYC = ns_to_cycles(T_DH_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC  = max_of(max_of(RD_CYC, OD_CYC), max_of(WP_CYC, HOLD_CYC));
  localparam int unsigned CW       = $clog2(MAX_CYC + 1);

  logic          load, expired, accept, rd_sample;
  logic [CW-1:0] load_val;
  strobe_t       strobe;

  sram_cycle_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sram_seq_fsm #(
    .CW(CW), .RD_CYC(RD_CYC), .OD_CYC(OD_CYC), .WP_CYC(WP_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .expired   (expired),
    .load      (load),
    .load_val  (load_val),
    .accept    (accept),
    .rd_sample (rd_sample),
    .strobe    (strobe),
    .ack       (req_ack)
  );

  sram_data_path #(.AW(ADDR_W), .DW(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_sample (rd_sample),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .wdata     (mem_dq_out),
    .rd_data   (rd_data)
  );

  assign mem_cs1_n = ~strobe.sel;
  assign mem_cs2   =  strobe.sel;
  assign mem_we_n  =  strobe.we_n;
  assign mem_oe_n  =  strobe.oe_n;
  assign mem_dq_oe =  strobe.drive;

  // R7: never drive while the memory may be driving
  a_r7_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R7: address and data hold still across the write pulse
  a_r7_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  // R8: strobe and selects end the write together
  a_r8_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_cs1_n && !mem_cs2));

  // R4: sampling happens while the memory is enabled for reading
  a_r4_sample_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample |-> (!mem_cs1_n && mem_we_n && !mem_oe_n));

  // R5: acknowledge arrives with the bus released
  a_r5_ack_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (mem_oe_n && !mem_dq_oe && mem_cs1_n));

endmodule

// File: tb/sram_cycle_ctrl_test.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_test;

  localparam int PER = 4;
  // Counts restated from the requirements (ceil of ns / period)
  localparam int RD = (70 + PER - 1) / PER;
  localparam int OD = (25 + PER - 1) / PER;
  localparam int WP = (70 + PER - 1) / PER;
  localparam int T_ACCESS = 70;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ack;
  logic [7:0]  rd_data;
  logic [16:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  always #(PER/2) clk = ~clk;

  sram_cycle_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory contents ----------------
  logic [7:0] dev_mem [logic [16:0]];   // what the device model holds
  logic [7:0] ref_mem [logic [16:0]];   // what the requirements say it holds

  function automatic logic [7:0] pat(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]};
  endfunction
  function logic [7:0] dev_rd(input logic [16:0] a);
    return dev_mem.exists(a) ? dev_mem[a] : pat(a);
  endfunction
  function logic [7:0] ref_rd(input logic [16:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : pat(a);
  endfunction

  // ---------------- reference model ----------------
  typedef struct packed {
    logic sel; logic we_n; logic oe_n; logic drive; logic ack; logic [2:0] seg;
  } exp_t;
  localparam exp_t E_IDLE = '{sel:0, we_n:1, oe_n:1, drive:0, ack:0, seg:3'd0};

  exp_t        q[$];
  exp_t        cur = E_IDLE;
  logic [16:0] m_addr = '0;
  logic [7:0]  m_data = '0;
  logic        m_write = 1'b0;
  logic [7:0]  m_exp_rd = '0;

  function automatic string seg_req(input logic [2:0] s);
    case (s)
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = E_IDLE;
    end else begin
      if (q.size() == 0 && req_valid && !cur.ack) begin
        m_addr  = req_addr;
        m_data  = req_wdata;
        m_write = req_write;
        if (req_write) begin
          for (int i = 0; i < WP; i++) q.push_back('{sel:1, we_n:0, oe_n:1, drive:1, ack:0, seg:3'd3});
          q.push_back('{sel:0, we_n:1, oe_n:1, drive:1, ack:0, seg:3'd4});
          ref_mem[req_addr] = req_wdata;
        end else begin
          m_exp_rd = ref_rd(req_addr);
          for (int i = 0; i < RD; i++) q.push_back('{sel:1, we_n:1, oe_n:0, drive:0, ack:0, seg:3'd1});
          for (int i = 0; i < OD; i++) q.push_back('{sel:0, we_n:1, oe_n:1, drive:0, ack:0, seg:3'd2});
        end
        q.push_back('{sel:0, we_n:1, oe_n:1, drive:0, ack:1, seg:3'd5});
      end
      cur = (q.size() != 0) ? q.pop_front() : E_IDLE;
    end
  end

  // ---------------- comparison and device model at the falling edge ----------------
  logic        prev_wr = 1'b0;
  logic [16:0] prev_addr = '0;
  logic [7:0]  prev_dq = '0;
  int          rd_age = 0;
  int          we_run = 0;
  int          oe_run = 0;

  always @(negedge clk) begin
    logic sel_now, wr_now, rd_now;
    logic [4:0] act_v, exp_v;
    sel_now = !mem_cs1_n && mem_cs2;
    wr_now  = sel_now && !mem_we_n;
    rd_now  = sel_now && mem_we_n && !mem_oe_n;
    act_v = {sel_now, mem_we_n, mem_oe_n, mem_dq_oe, req_ack};
    if (!rst_n) begin
      chk(act_v == 5'b01100, "R1", "pins in reset", 32'(act_v), 32'h0C);
    end else begin
      exp_v = {cur.sel, cur.we_n, cur.oe_n, cur.drive, cur.ack};
      chk(act_v == exp_v, seg_req(cur.seg), "sel/we_n/oe_n/drive/ack", 32'(act_v), 32'(exp_v));
      chk(mem_cs1_n == !mem_cs2, "R2", "select pair", {mem_cs1_n, mem_cs2}, 32'h2);
      if (cur.seg != 3'd0 && cur.seg != 3'd5)
        chk(mem_addr == m_addr, "R7", "address during cycle", 32'(mem_addr), 32'(m_addr));
      if (cur.drive)
        chk(mem_dq_out == m_data, "R7", "write data on bus", 32'(mem_dq_out), 32'(m_data));
      if (cur.ack && !m_write)
        chk(rd_data == m_exp_rd, "R4", "read data", 32'(rd_data), 32'(m_exp_rd));
      // R10: measured lengths of pulse and read window
      if (!mem_we_n) we_run++;
      else if (we_run != 0) begin
        chk(we_run == WP, "R10", "write pulse clocks", 32'(we_run), 32'(WP));
        we_run = 0;
      end
      if (!mem_oe_n) oe_run++;
      else if (oe_run != 0) begin
        chk(oe_run == RD, "R10", "read window clocks", 32'(oe_run), 32'(RD));
        oe_run = 0;
      end
    end
    // device: latch on the end of the write overlap
    if (prev_wr && !wr_now) dev_mem[prev_addr] = prev_dq;
    prev_wr   = wr_now;
    prev_addr = mem_addr;
    prev_dq   = mem_dq_oe ? mem_dq_out : 8'h5A;
    // device: data valid only after the access time
    if (rd_now) rd_age++; else rd_age = 0;
    mem_dq_in <= (rd_now && rd_age * PER >= T_ACCESS) ? dev_rd(mem_addr) : 8'hEE;
  end

  // ---------------- stimulus ----------------
  task automatic do_req(input logic w, input logic [16:0] a, input logic [7:0] d,
                        input int change_at, input bit keep);
    bit seen;
    seen = 1'b0;
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (change_at != 0 && i == change_at) begin
        req_addr  = a ^ 17'h15555;
        req_wdata = ~d;
      end
      if (req_ack) seen = 1'b1;
    end
    chk(seen, "R9", "acknowledge arrived", 32'(seen), 32'h1);
    if (!keep) req_valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reads of untouched locations (R3, R4, R5)
    do_req(1'b0, 17'h00000, 8'h00, 0, 1'b0);
    do_req(1'b0, 17'h1FFFF, 8'h00, 0, 1'b0);
    do_req(1'b0, 17'h0A5C3, 8'h00, 0, 1'b0);
    repeat (2) @(negedge clk);
    // writes then read-back (R6, R7, R8)
    do_req(1'b1, 17'h00010, 8'h3C, 0, 1'b0);
    do_req(1'b1, 17'h1FFFF, 8'hFF, 0, 1'b0);
    do_req(1'b1, 17'h00000, 8'h00, 0, 1'b0);
    do_req(1'b0, 17'h00010, 8'h00, 0, 1'b0);
    do_req(1'b0, 17'h1FFFF, 8'h00, 0, 1'b0);
    do_req(1'b0, 17'h00000, 8'h00, 0, 1'b0);
    // back-to-back with valid held (R9)
    do_req(1'b1, 17'h12345, 8'hA5, 0, 1'b1);
    do_req(1'b0, 17'h12345, 8'h00, 0, 1'b1);
    do_req(1'b1, 17'h00F0F, 8'h5A, 0, 1'b1);
    do_req(1'b0, 17'h00F0F, 8'h00, 0, 1'b0);
    // request inputs changed mid-cycle are ignored (R9)
    do_req(1'b1, 17'h04444, 8'h81, 5, 1'b0);
    do_req(1'b0, 17'h04444, 8'h00, 0, 1'b0);
    do_req(1'b0, 17'h04444 ^ 17'h15555, 8'h00, 0, 1'b0);
    do_req(1'b0, 17'h0A5C3, 8'h00, 9, 1'b0);
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * PER);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule